// File: doc/BRIEF.md
# Operand Forwarding Unit

This block resolves read-after-write hazards in a five-stage in-order integer pipeline without stalling. The instruction entering execute carries two source register numbers. The two instructions ahead of it, which sit in the execute/memory and memory/writeback pipeline registers, may be about to write one of those registers. For each operand the unit decides whether to use the register-file read, the newer result from the execute/memory register, or the older result from the memory/writeback register. It emits a 2-bit select code per operand.

The unit also contains the two three-input operand multiplexers, so the ALU operands can be seen directly at the ports. The whole block is combinational and holds no state. Load-use stalls, branch resolution, the register file and the ALU sit outside it.

Top module: `fwd_unit`

## Requirements
- R1: When the execute/memory stage has its write enable at 1, its destination is nonzero, and its destination equals an operand's source index, that operand's select is 1 (code 1 = execute/memory value).
- R2: When the memory/writeback stage has its write enable at 1, its destination is nonzero, it equals the source index, and R1 does not apply to that operand, the select is 2 (code 2 = memory/writeback value).
- R3: When neither R1 nor R2 applies, the select is 0 (code 0 = register-file value).
- R4: A write aimed at register 0 is never forwarded, whichever stage holds it, so a source index of 0 always selects code 0.
- R5: A stage whose write enable is 0 is never forwarded from, even when its destination matches.
- R6: When both stages match the same source, the execute/memory value wins with code 1.
- R7: The two operands are decided independently, each from its own source index only.
- R8: Each operand output equals the register-file value, the execute/memory value or the memory/writeback value for select 0, 1 or 2 respectively. Code 3 is never produced.
- R9: The outputs follow an input change within the same cycle, with no clock and no retained state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src1_idx | input | 5 | first source register index in decode/execute register |
| src2_idx | input | 5 | second source register index in decode/execute register |
| exm_dst | input | 5 | destination index in execute/memory register |
| exm_wen | input | 1 | register-write control in execute/memory register |
| exm_val | input | 32 | result held in execute/memory register |
| mwb_dst | input | 5 | destination index in memory/writeback register |
| mwb_wen | input | 1 | register-write control in memory/writeback register |
| mwb_val | input | 32 | result held in memory/writeback register |
| rf1_val | input | 32 | register-file read for first source |
| rf2_val | input | 32 | register-file read for second source |
| fwd1_sel | output | 2 | select code for first operand |
| fwd2_sel | output | 2 | select code for second operand |
| opnd1 | output | 32 | first ALU operand |
| opnd2 | output | 32 | second ALU operand |

## Verification
Whenever the inputs settle, the assertions check several properties: the priority of the newer stage, the exclusion of register 0 and of stages with write enable low, the conditions a memory/writeback select needs, and the agreement of each operand with its select. Only the bench's scenarios can show the rest. These are that both operands resolve separately when their sources differ, that back-to-back writers to one register resolve to the newer one, and that the outputs change within the cycle in which the inputs change.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_EXM = 2'd1,
    SEL_MWB = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_idx,
  input  logic [REG_W-1:0] exm_dst,
  input  logic             exm_wen,
  input  logic [REG_W-1:0] mwb_dst,
  input  logic             mwb_wen,
  output logic             exm_hit,
  output logic             mwb_hit,
  output fwd_pkg::fwd_sel_e sel
);
  import fwd_pkg::*;

  // A stage supplies a value when it writes, targets a real register and matches.
  function automatic logic writer_hits(input logic wen,
                                       input logic [REG_W-1:0] dst,
                                       input logic [REG_W-1:0] src);
    return wen && (dst != '0) && (dst == src);
  endfunction

  assign exm_hit = writer_hits(exm_wen, exm_dst, src_idx);
  assign mwb_hit = writer_hits(mwb_wen, mwb_dst, src_idx);

  always_comb begin
    if (exm_hit)      sel = SEL_EXM;
    else if (mwb_hit) sel = SEL_MWB;
    else              sel = SEL_RF;
  end

  always_comb begin
    // R4
    zero_src_chk: assert (src_idx != '0 || sel == SEL_RF);
    // R5
    no_wen_chk: assert (exm_wen || mwb_wen || sel == SEL_RF);
    // R6
    newer_wins_chk: assert (!(exm_wen && exm_dst == src_idx && src_idx != '0) || sel == SEL_EXM);
    // R2
    mwb_cond_chk: assert (sel != SEL_MWB ||
                          (mwb_wen && mwb_dst == src_idx && mwb_dst != '0 &&
                           !(exm_wen && exm_dst == src_idx)));
  end
endmodule

// File: rtl/fwd_mux3.sv
module fwd_mux3 #(
  parameter int DATA_W = 32
) (
  input  fwd_pkg::fwd_sel_e  sel,
  input  logic [DATA_W-1:0]  in_rf,
  input  logic [DATA_W-1:0]  in_exm,
  input  logic [DATA_W-1:0]  in_mwb,
  output logic [DATA_W-1:0]  dout
);
  import fwd_pkg::*;

  always_comb begin
    unique case (sel)
      SEL_EXM: dout = in_exm;
      SEL_MWB: dout = in_mwb;
      default: dout = in_rf;
    endcase
  end

  always_comb begin
    // R8
    sel_legal_chk: assert (sel != fwd_sel_e'(2'd3));
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  src1_idx,
  input  logic [REG_W-1:0]  src2_idx,
  input  logic [REG_W-1:0]  exm_dst,
  input  logic              exm_wen,
  input  logic [DATA_W-1:0] exm_val,
  input  logic [REG_W-1:0]  mwb_dst,
  input  logic              mwb_wen,
  input  logic [DATA_W-1:0] mwb_val,
  input  logic [DATA_W-1:0] rf1_val,
  input  logic [DATA_W-1:0] rf2_val,
  output logic [1:0]        fwd1_sel,
  output logic [1:0]        fwd2_sel,
  output logic [DATA_W-1:0] opnd1,
  output logic [DATA_W-1:0] opnd2
);
  import fwd_pkg::*;

  localparam int N_SRC = 2;

  logic [REG_W-1:0]  src_idx [N_SRC];
  logic [DATA_W-1:0] rf_val  [N_SRC];
  logic [DATA_W-1:0] opnd    [N_SRC];
  fwd_sel_e          sel     [N_SRC];
  logic              exm_hit [N_SRC];
  logic              mwb_hit [N_SRC];

  assign src_idx[0] = src1_idx;
  assign src_idx[1] = src2_idx;
  assign rf_val[0]  = rf1_val;
  assign rf_val[1]  = rf2_val;

  for (genvar g = 0; g < N_SRC; g++) begin : g_opnd
    fwd_match #(.REG_W(REG_W)) match_i (
      .src_idx (src_idx[g]),
      .exm_dst (exm_dst),
      .exm_wen (exm_wen),
      .mwb_dst (mwb_dst),
      .mwb_wen (mwb_wen),
      .exm_hit (exm_hit[g]),
      .mwb_hit (mwb_hit[g]),
      .sel     (sel[g])
    );

    fwd_mux3 #(.DATA_W(DATA_W)) mux_i (
      .sel    (sel[g]),
      .in_rf  (rf_val[g]),
      .in_exm (exm_val),
      .in_mwb (mwb_val),
      .dout   (opnd[g])
    );

    always_comb begin
      // R8
      opnd_src_chk: assert ((sel[g] == SEL_EXM && opnd[g] == exm_val) ||
                            (sel[g] == SEL_MWB && opnd[g] == mwb_val) ||
                            (sel[g] == SEL_RF  && opnd[g] == rf_val[g]));
      // R1
      exm_sel_chk: assert (!exm_hit[g] || sel[g] == SEL_EXM);
    end
  end

  assign fwd1_sel = sel[0];
  assign fwd2_sel = sel[1];
  assign opnd1    = opnd[0];
  assign opnd2    = opnd[1];
endmodule

// File: tb/fwd_unit_tb_top.sv
module fwd_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0]  src1_idx, src2_idx, exm_dst, mwb_dst;
  logic        exm_wen, mwb_wen;
  logic [31:0] exm_val, mwb_val, rf1_val, rf2_val, opnd1, opnd2;
  logic [1:0]  fwd1_sel, fwd2_sel;

  int errors = 0;
  int checks = 0;

  fwd_unit dut_i (
    .src1_idx(src1_idx), .src2_idx(src2_idx),
    .exm_dst(exm_dst), .exm_wen(exm_wen), .exm_val(exm_val),
    .mwb_dst(mwb_dst), .mwb_wen(mwb_wen), .mwb_val(mwb_val),
    .rf1_val(rf1_val), .rf2_val(rf2_val),
    .fwd1_sel(fwd1_sel), .fwd2_sel(fwd2_sel),
    .opnd1(opnd1), .opnd2(opnd2)
  );

  localparam logic [31:0] V_RF1 = 32'h1111_0001;
  localparam logic [31:0] V_RF2 = 32'h2222_0002;
  localparam logic [31:0] V_EXM = 32'hAAAA_000A;
  localparam logic [31:0] V_MWB = 32'hBBBB_000B;

  // {src1, src2, exm_dst, exm_wen, mwb_dst, mwb_wen, exp1, exp2}
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {5'd3,  5'd4,  5'd7,  1'b1, 5'd8,  1'b1, 2'd0, 2'd0},  // R3
    {5'd3,  5'd4,  5'd3,  1'b1, 5'd8,  1'b1, 2'd1, 2'd0},  // R1
    {5'd3,  5'd4,  5'd8,  1'b1, 5'd4,  1'b1, 2'd0, 2'd2},  // R2
    {5'd5,  5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 2'd1, 2'd1},  // R6
    {5'd6,  5'd9,  5'd6,  1'b0, 5'd6,  1'b1, 2'd2, 2'd0},  // R5
    {5'd6,  5'd9,  5'd6,  1'b0, 5'd9,  1'b0, 2'd0, 2'd0},  // R5
    {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'd0, 2'd0},  // R4
    {5'd0,  5'd2,  5'd0,  1'b1, 5'd2,  1'b1, 2'd0, 2'd2},  // R4
    {5'd31, 5'd31, 5'd31, 1'b1, 5'd1,  1'b0, 2'd1, 2'd1},  // R1
    {5'd12, 5'd13, 5'd13, 1'b1, 5'd12, 1'b1, 2'd2, 2'd1},  // R7
    {5'd1,  5'd1,  5'd0,  1'b1, 5'd1,  1'b1, 2'd2, 2'd2},  // R4
    {5'd4,  5'd4,  5'd0,  1'b0, 5'd4,  1'b0, 2'd0, 2'd0}   // R5
  };

  function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] rf);
    return (s == 2'd1) ? V_EXM : (s == 2'd2) ? V_MWB : rf;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [25:0] v);
    src1_idx = v[25:21]; src2_idx = v[20:16];
    exm_dst  = v[15:11]; exm_wen  = v[10];
    mwb_dst  = v[9:5];   mwb_wen  = v[4];
  endtask

  initial begin
    src1_idx = '0; src2_idx = '0; exm_dst = '0; mwb_dst = '0;
    exm_wen = 1'b0; mwb_wen = 1'b0;
    exm_val = V_EXM; mwb_val = V_MWB; rf1_val = V_RF1; rf2_val = V_RF2;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: idle inputs select the register file
    check("R3 idle sel1", {30'd0, fwd1_sel}, 32'd0);
    check("R3 idle sel2", {30'd0, fwd2_sel}, 32'd0);
    check("R8 idle opnd1", opnd1, V_RF1);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      drive(VEC[i]);
      @(negedge clk);
      check($sformatf("R7 vec%0d sel1", i), {30'd0, fwd1_sel}, {30'd0, VEC[i][3:2]});
      check($sformatf("R7 vec%0d sel2", i), {30'd0, fwd2_sel}, {30'd0, VEC[i][1:0]});
      check($sformatf("R8 vec%0d opnd1", i), opnd1, pick(VEC[i][3:2], V_RF1));
      check($sformatf("R8 vec%0d opnd2", i), opnd2, pick(VEC[i][1:0], V_RF2));
    end

    // R9: change inputs within a half cycle; outputs follow with no clock edge
    @(posedge clk);
    src1_idx = 5'd10; src2_idx = 5'd11; exm_dst = 5'd10; exm_wen = 1'b1;
    mwb_dst = 5'd11; mwb_wen = 1'b1;
    #0.5;
    check("R9 sel1 now", {30'd0, fwd1_sel}, 32'd1);
    check("R9 sel2 now", {30'd0, fwd2_sel}, 32'd2);
    exm_wen = 1'b0; mwb_wen = 1'b0;
    #0.5;
    check("R9 sel1 release", {30'd0, fwd1_sel}, 32'd0);
    check("R9 opnd2 release", opnd2, V_RF2);

    // R6: data values follow the newer writer when both stages target r7
    exm_val = 32'h0000_7777; mwb_val = 32'h0000_6666;
    src1_idx = 5'd7; exm_dst = 5'd7; mwb_dst = 5'd7; exm_wen = 1'b1; mwb_wen = 1'b1;
    #0.5;
    check("R6 opnd1 newer", opnd1, 32'h0000_7777);
    // R5: newer writer disabled, older one supplies
    exm_wen = 1'b0;
    #0.5;
    check("R5 opnd1 older", opnd1, 32'h0000_6666);
    // R4: both writers aim at r0, source r0 stays on register file
    src1_idx = 5'd0; exm_dst = 5'd0; mwb_dst = 5'd0; exm_wen = 1'b1;
    #0.5;
    check("R4 opnd1 zero", opnd1, V_RF1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule